// File: doc/BRIEF.md
# Nonvolatile Setting Commit Controller

This block keeps three 8-bit trim settings. Each setting has a live copy that drives the outputs and a second copy held in a modelled nonvolatile store. The store is a plain register array. Only the power-on reset `por_n` clears it, and it returns to the factory value 7Fh. A soft reset `rst_n` represents a power cycle. During a soft reset the store keeps its contents. After the reset is released, the block copies the stored values into the live registers, waits a start-up interval and then raises `ready_o`.

A serial front end decodes the bus and passes on three kinds of pulse: a start, a stop, and a write acknowledge with its register address and data. When a data byte is acknowledged, the block latches the register address and data as a pending write. Nothing is committed until a stop arrives. At the stop, the live register takes the new value and a timed programming cycle begins. `busy_o` stays high for the whole cycle, and the front end uses it to ignore the bus and withhold acknowledges. The stored copy is updated on the last cycle of programming. The block is idle whenever it is ready, not programming and holding no pending write.

Top module: `nv_commit_ctrl`

## Requirements
- R1: After a power-on reset, every setting reads 7Fh once `ready_o` is high.
- R2: During reset, `ready_o`, `busy_o` and all settings are 0. After reset is released, `ready_o` stays low for exactly STARTUP_CYC clock edges, then rises and stays high.
- R3: After a soft reset, each setting is restored to the last value whose programming cycle completed.
- R4: An acknowledged write to register address F8h+i (i = 0, 1, 2) sets bits [8i+7:8i] of `settings_o`. The value appears the cycle after the stop, not when the byte is acknowledged.
- R5: A stop that finds a pending write raises `busy_o` on the next edge. `busy_o` then stays high for exactly WRITE_CYC cycles.
- R6: While `busy_o` is high, every acknowledge, start and stop is ignored. This includes an acknowledge in the last busy cycle. The settings do not change and the busy window is not extended.
- R7: A start that arrives after an acknowledged byte and before a stop discards the pending write. The stop that follows commits nothing.
- R8: An acknowledge with a register address outside F8h..FAh creates no pending write.
- R9: A stop with no pending write starts no programming cycle.
- R10: An acknowledge that arrives in the same cycle as a stop is dropped.
- R11: `idle_o` is high exactly when the block is ready, not busy and holds no pending write.
- R12: A soft reset during programming leaves the stored value unchanged, so the later recall returns the previously stored value.
- R13: Acknowledges and stops that arrive before `ready_o` rises are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; clears the store to 7Fh and resets the logic |
| rst_n | input | 1 | Soft reset, active low; the store is kept |
| bus_start_i | input | 1 | Pulse: start or repeated start seen on the bus |
| bus_stop_i | input | 1 | Pulse: stop seen on the bus |
| wr_ack_i | input | 1 | Pulse: data byte of a write acknowledged |
| wr_addr_i | input | 8 | Register address of the acknowledged write |
| wr_data_i | input | DW | Data byte of the acknowledged write |
| settings_o | output | NREG*DW | Live settings, register i in bits [8i+7:8i] |
| ready_o | output | 1 | Start-up recall finished |
| busy_o | output | 1 | Programming cycle under way; the bus must be ignored |
| idle_o | output | 1 | Low-power idle state |

## Verification
Two events can fall in the same cycle. One is the end of a programming cycle, when the stored copy is written and `busy_o` drops. The other is a new acknowledge from the front end. The bench provokes the collision by raising an acknowledge in the last cycle where `busy_o` is still high. It then checks that `busy_o` falls on schedule and that no pending write remains (`idle_o` high). A following stop must start no new cycle. In the same way, a stop and an acknowledge are driven in the same cycle, and the bench judges that case against R10.

// File: rtl/nvc_pkg.sv
package nvc_pkg;

  typedef enum logic [1:0] {
    PH_BOOT,
    PH_RUN,
    PH_PROG
  } nvc_phase_e;

  // Signed distance of a register address from the bank base address.
  function automatic int slot_offset(input logic [7:0] addr, input logic [7:0] base);
    return int'(addr) - int'(base);
  endfunction

  // True when the address falls inside a bank of n registers.
  function automatic logic slot_in_bank(input logic [7:0] addr, input logic [7:0] base,
                                        input int n);
    int off;
    off = slot_offset(addr, base);
    return (off >= 0) && (off < n);
  endfunction

endpackage

// File: rtl/nvc_seq.sv
module nvc_seq
  import nvc_pkg::*;
#(
  parameter int unsigned STARTUP_CYC = 250000,
  parameter int unsigned WRITE_CYC   = 2500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_i,
  input  logic pending_i,
  output logic ready_o,
  output logic busy_o,
  output logic recall_o,
  output logic commit_o,
  output logic done_o
);
  localparam int unsigned MAXC = (STARTUP_CYC > WRITE_CYC) ? STARTUP_CYC : WRITE_CYC;
  localparam int unsigned CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] BOOT_LAST = CW'(STARTUP_CYC - 1);
  localparam logic [CW-1:0] PROG_LAST = CW'(WRITE_CYC - 1);

  nvc_phase_e    ph;
  logic [CW-1:0] cnt;

  assign recall_o = (ph == PH_BOOT) && (cnt == '0);
  assign commit_o = (ph == PH_RUN) && stop_i && pending_i;
  assign done_o   = (ph == PH_PROG) && (cnt == PROG_LAST);
  assign ready_o  = (ph != PH_BOOT);
  assign busy_o   = (ph == PH_PROG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= PH_BOOT;
      cnt <= '0;
    end else begin
      unique case (ph)
        PH_BOOT: begin
          if (cnt == BOOT_LAST) begin
            ph  <= PH_RUN;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_RUN: begin
          if (commit_o) begin
            ph  <= PH_PROG;
            cnt <= '0;
          end
        end
        PH_PROG: begin
          if (done_o) begin
            ph  <= PH_RUN;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          ph  <= PH_BOOT;
          cnt <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/nvc_pending.sv
module nvc_pending #(
  parameter int unsigned DW = 8,
  parameter int unsigned IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take_i,
  input  logic          drop_i,
  input  logic          clear_i,
  input  logic [IW-1:0] idx_i,
  input  logic [DW-1:0] data_i,
  output logic          pend_o,
  output logic [IW-1:0] idx_o,
  output logic [DW-1:0] data_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_o <= 1'b0;
      idx_o  <= '0;
      data_o <= '0;
    end else if (clear_i) begin
      pend_o <= 1'b0;
    end else if (take_i) begin
      pend_o <= 1'b1;
      idx_o  <= idx_i;
      data_o <= data_i;
    end else if (drop_i) begin
      pend_o <= 1'b0;
    end
  end

endmodule

// File: rtl/nvc_bank.sv
module nvc_bank #(
  parameter int unsigned  NREG        = 3,
  parameter int unsigned  DW          = 8,
  parameter int unsigned  IW          = 2,
  parameter logic [DW-1:0] DEFAULT_VAL = 8'h7F
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            rst_n,
  input  logic            recall_i,
  input  logic            commit_i,
  input  logic            done_i,
  input  logic [IW-1:0]   idx_i,
  input  logic [DW-1:0]   data_i,
  output logic [NREG*DW-1:0] live_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_slot
    logic [DW-1:0] store_q;
    logic [DW-1:0] live_q;
    logic          hit;

    assign hit = (idx_i == IW'(g));

    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)              store_q <= DEFAULT_VAL;
      else if (done_i && hit)  store_q <= data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               live_q <= '0;
      else if (recall_i)        live_q <= store_q;
      else if (commit_i && hit) live_q <= data_i;
    end

    assign live_o[g*DW +: DW] = live_q;
  end

endmodule

// File: rtl/nv_commit_ctrl.sv
module nv_commit_ctrl
  import nvc_pkg::*;
#(
  parameter int unsigned   NREG        = 3,
  parameter int unsigned   DW          = 8,
  parameter logic [7:0]    BASE_ADDR   = 8'hF8,
  parameter logic [DW-1:0] DEFAULT_VAL = 8'h7F,
  parameter int unsigned   STARTUP_CYC = 250000,
  parameter int unsigned   WRITE_CYC   = 2500000
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               rst_n,
  input  logic               bus_start_i,
  input  logic               bus_stop_i,
  input  logic               wr_ack_i,
  input  logic [7:0]         wr_addr_i,
  input  logic [DW-1:0]      wr_data_i,
  output logic [NREG*DW-1:0] settings_o,
  output logic               ready_o,
  output logic               busy_o,
  output logic               idle_o
);
  localparam int unsigned IW = (NREG > 1) ? $clog2(NREG) : 1;

  // Named internal events, brought out for the checker.
  logic          sys_rst_n;
  logic          addr_ok;
  int            slot_off;
  logic [IW-1:0] slot;
  logic          take_wr;
  logic          recall;
  logic          commit;
  logic          done;
  logic          pend;
  logic [IW-1:0] pidx;
  logic [DW-1:0] pdata;

  assign sys_rst_n = por_n & rst_n;
  assign slot_off  = slot_offset(wr_addr_i, BASE_ADDR);
  assign addr_ok   = slot_in_bank(wr_addr_i, BASE_ADDR, NREG);
  assign slot      = IW'(slot_off);
  assign take_wr   = wr_ack_i && addr_ok && ready_o && !busy_o && !bus_stop_i;
  assign idle_o    = ready_o && !busy_o && !pend;

  nvc_seq #(
    .STARTUP_CYC(STARTUP_CYC),
    .WRITE_CYC  (WRITE_CYC)
  ) u_seq (
    .clk      (clk),
    .rst_n    (sys_rst_n),
    .stop_i   (bus_stop_i),
    .pending_i(pend),
    .ready_o  (ready_o),
    .busy_o   (busy_o),
    .recall_o (recall),
    .commit_o (commit),
    .done_o   (done)
  );

  nvc_pending #(
    .DW(DW),
    .IW(IW)
  ) u_pend (
    .clk    (clk),
    .rst_n  (sys_rst_n),
    .take_i (take_wr),
    .drop_i (bus_start_i),
    .clear_i(commit),
    .idx_i  (slot),
    .data_i (wr_data_i),
    .pend_o (pend),
    .idx_o  (pidx),
    .data_o (pdata)
  );

  nvc_bank #(
    .NREG       (NREG),
    .DW         (DW),
    .IW         (IW),
    .DEFAULT_VAL(DEFAULT_VAL)
  ) u_bank (
    .clk     (clk),
    .por_n   (por_n),
    .rst_n   (sys_rst_n),
    .recall_i(recall),
    .commit_i(commit),
    .done_i  (done),
    .idx_i   (pidx),
    .data_i  (pdata),
    .live_o  (settings_o)
  );

endmodule

// File: rtl/nv_commit_ctrl_chk.sv
module nv_commit_ctrl_chk #(
  parameter int unsigned NREG      = 3,
  parameter int unsigned DW        = 8,
  parameter int unsigned IW        = 2,
  parameter int unsigned WRITE_CYC = 2500000
) (
  input logic               clk,
  input logic               por_n,
  input logic               rst_n,
  input logic               bus_start_i,
  input logic               bus_stop_i,
  input logic               wr_ack_i,
  input logic               addr_ok,
  input logic [NREG*DW-1:0] settings_o,
  input logic               ready_o,
  input logic               busy_o,
  input logic               idle_o,
  input logic               commit,
  input logic               pend,
  input logic [IW-1:0]      pidx,
  input logic [DW-1:0]      pdata
);
  int unsigned run;

  always_ff @(posedge clk or negedge rst_n or negedge por_n) begin
    if (!rst_n || !por_n) run <= 0;
    else if (busy_o)      run <= run + 1;
    else                  run <= 0;
  end

  p_ready_holds_r2: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    ready_o |=> ready_o);

  p_no_busy_boot_r2: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    !ready_o |-> !busy_o);

  p_commit_value_r4: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    commit |=> (settings_o[int'(pidx)*DW +: DW] == $past(pdata)));

  p_busy_follows_stop_r5: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (ready_o && !busy_o && bus_stop_i && pend) |=> busy_o);

  p_busy_length_r5: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (!busy_o && $past(busy_o)) |-> (run == WRITE_CYC));

  p_busy_bound_r5: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    busy_o |-> (run < WRITE_CYC));

  p_frozen_busy_r6: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    busy_o |=> $stable(settings_o));

  p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (bus_start_i && !wr_ack_i && !bus_stop_i) |=> !pend);

  p_bad_addr_r8: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (wr_ack_i && !addr_ok && !bus_start_i && !bus_stop_i) |=> (pend == $past(pend)));

  p_stop_empty_r9: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (bus_stop_i && !pend && !busy_o) |=> !busy_o);

  p_ack_with_stop_r10: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (bus_stop_i && wr_ack_i) |=> !pend);

  p_idle_busy_r11: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    busy_o |-> !idle_o);

  p_early_ack_r13: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    !ready_o |=> !pend);

endmodule

bind nv_commit_ctrl nv_commit_ctrl_chk #(
  .NREG     (NREG),
  .DW       (DW),
  .IW       (IW),
  .WRITE_CYC(WRITE_CYC)
) u_chk (
  .clk        (clk),
  .por_n      (por_n),
  .rst_n      (rst_n),
  .bus_start_i(bus_start_i),
  .bus_stop_i (bus_stop_i),
  .wr_ack_i   (wr_ack_i),
  .addr_ok    (addr_ok),
  .settings_o (settings_o),
  .ready_o    (ready_o),
  .busy_o     (busy_o),
  .idle_o     (idle_o),
  .commit     (commit),
  .pend       (pend),
  .pidx       (pidx),
  .pdata      (pdata)
);

// File: tb/nv_commit_ctrl_bench.sv
module nv_commit_ctrl_bench;
  localparam int S = 5;
  localparam int W = 10;

  logic        clk = 1'b0;
  logic        por_n, rst_n, start, stop, ack;
  logic [7:0]  addr, data;
  logic [23:0] settings;
  logic        ready, busy, idle;

  int    checks = 0;
  int    fails  = 0;
  int    cyc    = 0;
  string cur_req = "R2";

  always #4 clk = ~clk;

  nv_commit_ctrl #(
    .STARTUP_CYC(S),
    .WRITE_CYC  (W)
  ) u_nv_commit_ctrl (
    .clk        (clk),
    .por_n      (por_n),
    .rst_n      (rst_n),
    .bus_start_i(start),
    .bus_stop_i (stop),
    .wr_ack_i   (ack),
    .wr_addr_i  (addr),
    .wr_data_i  (data),
    .settings_o (settings),
    .ready_o    (ready),
    .busy_o     (busy),
    .idle_o     (idle)
  );

  // Behavioural reference model.
  int m_store[3];
  int m_live[3];
  bit m_ready;
  int m_boot, m_left;
  bit m_pend;
  int m_pidx, m_pdata;

  always @(posedge clk) begin
    if (!por_n) foreach (m_store[i]) m_store[i] = 'h7F;
    if (!por_n || !rst_n) begin
      foreach (m_live[i]) m_live[i] = 0;
      m_ready = 0; m_boot = 0; m_left = 0; m_pend = 0;
    end else if (!m_ready) begin
      if (m_boot == 0) foreach (m_live[i]) m_live[i] = m_store[i];
      m_boot++;
      if (m_boot == S) m_ready = 1;
    end else if (m_left > 0) begin
      m_left--;
      if (m_left == 0) m_store[m_pidx] = m_pdata;
    end else if (stop) begin
      if (m_pend) begin
        m_live[m_pidx] = m_pdata;
        m_left = W;
        m_pend = 0;
      end
    end else if (ack && addr >= 8'hF8 && addr <= 8'hFA) begin
      m_pend = 1; m_pidx = int'(addr) - 'hF8; m_pdata = int'(data);
    end else if (start) begin
      m_pend = 0;
    end
  end

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    logic [23:0] exp_set;
    #3;
    for (int i = 0; i < 3; i++) exp_set[i*8 +: 8] = m_live[i][7:0];
    checks++;
    if (settings !== exp_set || ready !== m_ready || busy !== (m_left > 0) ||
        idle !== (m_ready && m_left == 0 && !m_pend)) begin
      fails++;
      $display("FAIL %s model: act set=%h rdy=%b bsy=%b idl=%b exp set=%h rdy=%b bsy=%b idl=%b",
               cur_req, settings, ready, busy, idle, exp_set, m_ready, m_left > 0,
               m_ready && m_left == 0 && !m_pend);
    end
    cyc++;
    if (cyc > 5000) begin
      fails++;
      $display("FAIL watchdog act=hung exp=done");
      finish_up();
    end
  end

  // Length of the last busy window, seen at falling edges.
  int run = 0, last_len = 0;
  always @(negedge clk) begin
    if (busy) run++;
    else if (run > 0) begin last_len = run; run = 0; end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    start = 1; @(negedge clk); start = 0;
  endtask
  task automatic pulse_stop();
    stop = 1; @(negedge clk); stop = 0;
  endtask
  task automatic put_ack(input logic [7:0] a, input logic [7:0] d);
    ack = 1; addr = a; data = d; @(negedge clk); ack = 0;
  endtask
  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    por_n = 0; rst_n = 0; start = 0; stop = 0; ack = 0; addr = 0; data = 0;
    repeat (3) @(negedge clk);
    cur_req = "R2";
    chk("R2 reset ready", ready, 0);
    chk("R2 reset busy", busy, 0);
    chk("R2 reset settings", settings, 0);
    por_n = 1; rst_n = 1;
    // R13: write attempt during start-up
    cur_req = "R13";
    ack = 1; addr = 8'hF8; data = 8'h11;
    @(negedge clk); ack = 0; stop = 1;
    @(negedge clk); stop = 0;
    repeat (2) @(negedge clk);
    chk("R2 ready low before end", ready, 0);
    @(negedge clk);
    chk("R2 ready high", ready, 1);
    chk("R1 defaults", settings, 24'h7F7F7F);
    chk("R13 early write ignored busy", busy, 0);

    // R4 / R5 / R6
    cur_req = "R4";
    pulse_start();
    put_ack(8'hF9, 8'h80);
    chk("R4 no change before stop", settings[15:8], 8'h7F);
    chk("R11 pending not idle", idle, 0);
    pulse_stop();
    chk("R4 value at stop", settings[15:8], 8'h80);
    chk("R5 busy after stop", busy, 1);
    cur_req = "R6";
    put_ack(8'hFA, 8'h33);
    pulse_stop();
    wait_idle();
    chk("R5 busy length", last_len, W);
    chk("R6 ignored during busy", settings[23:16], 8'h7F);
    chk("R6 no new cycle", busy, 0);
    chk("R11 idle after programming", idle, 1);

    // R7 abort by repeated start
    cur_req = "R7";
    pulse_start();
    put_ack(8'hF8, 8'h22);
    pulse_start();
    pulse_stop();
    chk("R7 abort no busy", busy, 0);
    chk("R7 abort no change", settings[7:0], 8'h7F);
    chk("R7 idle", idle, 1);

    // R8 / R9
    cur_req = "R8";
    pulse_start();
    put_ack(8'hFB, 8'h44);
    chk("R8 high address ignored", idle, 1);
    put_ack(8'hF7, 8'h45);
    chk("R8 low address ignored", idle, 1);
    pulse_stop();
    chk("R8 no busy", busy, 0);
    cur_req = "R9";
    pulse_stop();
    chk("R9 lone stop", busy, 0);

    // R10 ack and stop in one cycle
    cur_req = "R10";
    pulse_start();
    ack = 1; stop = 1; addr = 8'hF8; data = 8'h55;
    @(negedge clk); ack = 0; stop = 0;
    chk("R10 no busy", busy, 0);
    chk("R10 no change", settings[7:0], 8'h7F);
    chk("R10 idle", idle, 1);

    // Collision: ack in the last busy cycle
    cur_req = "R6";
    pulse_start();
    put_ack(8'hF8, 8'h01);
    pulse_stop();
    repeat (W - 1) @(negedge clk);
    chk("R6 still busy in last cycle", busy, 1);
    ack = 1; addr = 8'hF8; data = 8'h99;
    @(negedge clk); ack = 0;
    chk("R6 busy ends on time", busy, 0);
    chk("R6 late ack dropped", idle, 1);
    pulse_stop();
    chk("R6 late ack no cycle", busy, 0);
    chk("R6 value kept", settings[7:0], 8'h01);

    // R3 recall after soft reset
    cur_req = "R3";
    rst_n = 0; repeat (2) @(negedge clk); rst_n = 1;
    repeat (S + 1) @(negedge clk);
    chk("R3 ready", ready, 1);
    chk("R3 recall", settings, 24'h7F8001);

    // R12 soft reset during programming
    cur_req = "R12";
    pulse_start();
    put_ack(8'hF8, 8'h5A);
    pulse_stop();
    chk("R12 live updated", settings[7:0], 8'h5A);
    repeat (3) @(negedge clk);
    rst_n = 0; repeat (2) @(negedge clk); rst_n = 1;
    repeat (S + 1) @(negedge clk);
    chk("R12 old value recalled", settings[7:0], 8'h01);

    // R1 power-on restores factory value
    cur_req = "R1";
    por_n = 0; repeat (2) @(negedge clk); por_n = 1;
    repeat (S + 1) @(negedge clk);
    chk("R1 factory after power-on", settings, 24'h7F7F7F);

    finish_up();
  end

endmodule